// File: doc/BRIEF.md
# Write Buffer Drain Controller

This block sits in a memory controller that has a single data bus for both reads and writes. Each reversal of the bus direction wastes cycles, so writes are not sent as they arrive. They collect in a first-in first-out buffer and are sent out in bursts. While the controller serves reads, buffered writes stay where they are. Once enough writes have accumulated, the controller switches to draining. It leaves the drain and returns to reads when the buffer has gone down far enough.

Two configuration inputs set the switch points. An upper fill level starts a drain, and a lower fill level ends a drain while reads are waiting. Because the two levels differ, the controller does not toggle between modes on every write. When no reads are waiting and the buffer holds anything, the controller drains anyway. Each change of direction is followed by an idle gap whose length is a configuration input. During that gap neither reads nor writes may issue. A mode output tells the read path and the command issuer which direction owns the bus.

Top module: `wbuf_drain_ctrl`

## Requirements
- R1: After reset, busMode is READ (2'b00), fillLevel is 0, enqReady is 1 and deqValid is 0.
- R2: An entry is accepted on a cycle with enqValid and enqReady both high, and fillLevel then goes up by one. When fillLevel equals DEPTH, enqReady is 0 and enqValid leaves fillLevel unchanged.
- R3: deqValid is 0 whenever busMode is not WRITE (2'b01).
- R4: In READ with rdPending high, the controller leaves READ on the clock edge that follows a cycle in which fillLevel is at least highMark.
- R5: In READ with rdPending low, the controller leaves READ on the clock edge that follows a cycle in which fillLevel is non-zero, even if fillLevel is below highMark.
- R6: Each change of direction passes through busMode TURN (2'b10) for exactly turnCycles cycles. When turnCycles is 0, the mode switches directly. busMode never takes the value 2'b11.
- R7: In WRITE with rdPending high, deqValid is high while fillLevel is above lowMark. When fillLevel is at or below lowMark, deqValid is 0 and the controller leaves WRITE at the next edge.
- R8: In WRITE with rdPending low, the controller drains until fillLevel is 0, then leaves WRITE at the next edge.
- R9: deqData presents the oldest buffered entry (first in, first out). An entry is removed only on a cycle with deqValid and deqReady both high, and deqData holds its value while deqValid is high and deqReady is low.
- R10: On a cycle with both an accepted enqueue and a dequeue, fillLevel stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| highMark | input | CNT_W | Fill level at which a drain starts |
| lowMark | input | CNT_W | Fill level at which a drain ends while reads wait (below highMark) |
| turnCycles | input | TURN_W | Idle cycles inserted on each direction change |
| enqValid | input | 1 | Write request present |
| enqData | input | ENTRY_W | Write request payload |
| enqReady | output | 1 | Buffer can accept a write |
| rdPending | input | 1 | At least one read is waiting |
| deqValid | output | 1 | A buffered write may issue now |
| deqData | output | ENTRY_W | Oldest buffered write |
| deqReady | input | 1 | Command issuer takes the write |
| busMode | output | 2 | 00 read, 01 write drain, 10 turnaround |
| fillLevel | output | CNT_W | Current buffer occupancy |

## Verification
The bench builds the block with DEPTH 4 and ENTRY_W 8. A four-entry buffer reaches the full state after a few pushes, so back-pressure can be tested alongside a pending drain. The bench sets highMark 3, lowMark 1 and turnCycles 2. With these values the hysteresis stop point, the opportunistic drain and both two-cycle gaps each appear within a handful of cycles. A later pass sets turnCycles to 0 to cover the direct mode switch.

// File: rtl/wdc_pkg.sv
package wdc_pkg;

  typedef enum logic [1:0] {
    ST_READ     = 2'd0,
    ST_TO_WRITE = 2'd1,
    ST_WRITE    = 2'd2,
    ST_TO_READ  = 2'd3
  } wdc_state_e;

  localparam logic [1:0] MODE_READ  = 2'b00;
  localparam logic [1:0] MODE_WRITE = 2'b01;
  localparam logic [1:0] MODE_TURN  = 2'b10;

  typedef struct packed {
    logic push;
    logic pop;
  } wdc_strobe_t;

endpackage

// File: rtl/wdc_datapath.sv
module wdc_datapath
  import wdc_pkg::*;
#(
  parameter int ENTRY_W = 32,
  parameter int DEPTH   = 8,
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  wdc_strobe_t        strobe,
  input  logic [ENTRY_W-1:0] wrData,
  output logic [ENTRY_W-1:0] rdData,
  output logic [CNT_W-1:0]   count,
  output logic               full
);

  logic [ENTRY_W-1:0] store [DEPTH];
  logic [PTR_W-1:0]   wrPtr;
  logic [PTR_W-1:0]   rdPtr;
  logic [PTR_W-1:0]   wrPtrNext;
  logic [PTR_W-1:0]   rdPtrNext;

  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);

  // Pointer advance: power-of-two depths wrap naturally, others compare.
  generate
    if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign wrPtrNext = wrPtr + PTR_W'(1);
      assign rdPtrNext = rdPtr + PTR_W'(1);
    end else begin : g_generic
      assign wrPtrNext = (wrPtr == LAST_IDX) ? '0 : wrPtr + PTR_W'(1);
      assign rdPtrNext = (rdPtr == LAST_IDX) ? '0 : rdPtr + PTR_W'(1);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (strobe.push) store[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (strobe.push) wrPtr <= wrPtrNext;
      if (strobe.pop)  rdPtr <= rdPtrNext;
      unique case ({strobe.push, strobe.pop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  assign rdData = store[rdPtr];
  assign full   = (count == CNT_W'(DEPTH));

endmodule

// File: rtl/wdc_control.sv
module wdc_control
  import wdc_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int TURN_W = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CNT_W-1:0]  highMark,
  input  logic [CNT_W-1:0]  lowMark,
  input  logic [TURN_W-1:0] turnCycles,
  input  logic [CNT_W-1:0]  count,
  input  logic              full,
  input  logic              enqValid,
  input  logic              rdPending,
  input  logic              deqReady,
  output logic              enqReady,
  output logic              deqValid,
  output logic [1:0]        busMode,
  output wdc_strobe_t       strobe
);

  wdc_state_e        state;
  wdc_state_e        stateNext;
  logic [TURN_W-1:0] turnCnt;
  logic              loadTurn;
  logic              drainTrig;
  logic              exitNow;
  logic              noGap;

  assign noGap     = (turnCycles == '0);
  assign drainTrig = (count >= highMark) || ((count != '0) && !rdPending);
  assign exitNow   = (count == '0) || (rdPending && (count <= lowMark));

  always_comb begin
    stateNext = state;
    loadTurn  = 1'b0;
    unique case (state)
      ST_READ: begin
        if (drainTrig) begin
          if (noGap) stateNext = ST_WRITE;
          else begin
            stateNext = ST_TO_WRITE;
            loadTurn  = 1'b1;
          end
        end
      end
      ST_TO_WRITE: begin
        if (turnCnt == '0) stateNext = ST_WRITE;
      end
      ST_WRITE: begin
        if (exitNow) begin
          if (noGap) stateNext = ST_READ;
          else begin
            stateNext = ST_TO_READ;
            loadTurn  = 1'b1;
          end
        end
      end
      ST_TO_READ: begin
        if (turnCnt == '0) stateNext = ST_READ;
      end
      default: stateNext = ST_READ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_READ;
      turnCnt <= '0;
    end else begin
      state <= stateNext;
      if (loadTurn)
        turnCnt <= turnCycles - TURN_W'(1);
      else if (turnCnt != '0)
        turnCnt <= turnCnt - TURN_W'(1);
    end
  end

  always_comb begin
    unique case (state)
      ST_READ:  busMode = MODE_READ;
      ST_WRITE: busMode = MODE_WRITE;
      default:  busMode = MODE_TURN;
    endcase
  end

  assign enqReady    = !full;
  assign deqValid    = (state == ST_WRITE) && !exitNow;
  assign strobe.push = enqValid && !full;
  assign strobe.pop  = deqValid && deqReady;

endmodule

// File: rtl/wbuf_drain_ctrl.sv
module wbuf_drain_ctrl
  import wdc_pkg::*;
#(
  parameter int ENTRY_W = 32,
  parameter int DEPTH   = 8,
  parameter int TURN_W  = 4,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [CNT_W-1:0]   highMark,
  input  logic [CNT_W-1:0]   lowMark,
  input  logic [TURN_W-1:0]  turnCycles,
  input  logic               enqValid,
  input  logic [ENTRY_W-1:0] enqData,
  output logic               enqReady,
  input  logic               rdPending,
  output logic               deqValid,
  output logic [ENTRY_W-1:0] deqData,
  input  logic               deqReady,
  output logic [1:0]         busMode,
  output logic [CNT_W-1:0]   fillLevel
);

  wdc_strobe_t strobe;
  logic        full;

  wdc_control #(
    .DEPTH (DEPTH),
    .TURN_W(TURN_W)
  ) u_control (
    .clk       (clk),
    .rstN      (rstN),
    .highMark  (highMark),
    .lowMark   (lowMark),
    .turnCycles(turnCycles),
    .count     (fillLevel),
    .full      (full),
    .enqValid  (enqValid),
    .rdPending (rdPending),
    .deqReady  (deqReady),
    .enqReady  (enqReady),
    .deqValid  (deqValid),
    .busMode   (busMode),
    .strobe    (strobe)
  );

  wdc_datapath #(
    .ENTRY_W(ENTRY_W),
    .DEPTH  (DEPTH)
  ) u_datapath (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .wrData(enqData),
    .rdData(deqData),
    .count (fillLevel),
    .full  (full)
  );

endmodule

// File: rtl/wdc_checker.sv
module wdc_checker #(
  parameter int ENTRY_W = 32,
  parameter int DEPTH   = 8,
  parameter int TURN_W  = 4,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input logic               clk,
  input logic               rstN,
  input logic [CNT_W-1:0]   lowMark,
  input logic [TURN_W-1:0]  turnCycles,
  input logic               enqValid,
  input logic               enqReady,
  input logic               rdPending,
  input logic               deqValid,
  input logic [ENTRY_W-1:0] deqData,
  input logic               deqReady,
  input logic [1:0]         busMode,
  input logic [CNT_W-1:0]   fillLevel
);

  logic pushSeen;
  logic popSeen;
  assign pushSeen = enqValid && enqReady;
  assign popSeen  = deqValid && deqReady;

  // R3
  no_deq_outside_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busMode != 2'b01) |-> !deqValid);

  // R2
  full_backpressure_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fillLevel == CNT_W'(DEPTH)) |-> !enqReady);

  // R10
  fill_track_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (fillLevel == $past(fillLevel) + CNT_W'($past(pushSeen)) - CNT_W'($past(popSeen))));

  // R7
  no_drain_below_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdPending && busMode == 2'b01 && fillLevel <= lowMark) |-> !deqValid);

  // R6
  gap_before_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busMode == 2'b00 && turnCycles != '0) |=> (busMode != 2'b01));

  // R6
  mode_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    busMode != 2'b11);

  // R9
  head_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (deqValid && !deqReady) |=> $stable(deqData));

endmodule

bind wbuf_drain_ctrl wdc_checker #(
  .ENTRY_W(ENTRY_W),
  .DEPTH  (DEPTH),
  .TURN_W (TURN_W)
) u_checker (
  .clk       (clk),
  .rstN      (rstN),
  .lowMark   (lowMark),
  .turnCycles(turnCycles),
  .enqValid  (enqValid),
  .enqReady  (enqReady),
  .rdPending (rdPending),
  .deqValid  (deqValid),
  .deqData   (deqData),
  .deqReady  (deqReady),
  .busMode   (busMode),
  .fillLevel (fillLevel)
);

// File: tb/wbuf_drain_ctrl_bench.sv
module wbuf_drain_ctrl_bench;

  localparam int ENTRY_W = 8;
  localparam int DEPTH   = 4;
  localparam int TURN_W  = 4;
  localparam int CNT_W   = $clog2(DEPTH + 1);
  localparam int NVEC    = 32;

  typedef struct packed {
    logic             ev;
    logic [7:0]       ed;
    logic             rp;
    logic             dr;
    logic [1:0]       mode;
    logic [CNT_W-1:0] fill;
    logic             er;
    logic             dv;
    logic [7:0]       data;
  } vec_t;

  // Config: highMark 3, lowMark 1, turnCycles 2. Modes: 0 read, 1 write, 2 turn.
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 8'h00, 1'b1, 1'b1, 2'd0, 3'd0, 1'b1, 1'b0, 8'h00}, // 0  R1 idle
    '{1'b1, 8'hA1, 1'b1, 1'b1, 2'd0, 3'd0, 1'b1, 1'b0, 8'h00}, // 1  R2 push
    '{1'b1, 8'hA2, 1'b1, 1'b1, 2'd0, 3'd1, 1'b1, 1'b0, 8'h00}, // 2
    '{1'b1, 8'hA3, 1'b1, 1'b1, 2'd0, 3'd2, 1'b1, 1'b0, 8'h00}, // 3  R3 held in read
    '{1'b0, 8'h00, 1'b1, 1'b1, 2'd0, 3'd3, 1'b1, 1'b0, 8'h00}, // 4  R4 high reached
    '{1'b0, 8'h00, 1'b1, 1'b1, 2'd2, 3'd3, 1'b1, 1'b0, 8'h00}, // 5  R6 gap 1
    '{1'b0, 8'h00, 1'b1, 1'b1, 2'd2, 3'd3, 1'b1, 1'b0, 8'h00}, // 6  R6 gap 2
    '{1'b0, 8'h00, 1'b1, 1'b1, 2'd1, 3'd3, 1'b1, 1'b1, 8'hA1}, // 7  R9 oldest first
    '{1'b0, 8'h00, 1'b1, 1'b1, 2'd1, 3'd2, 1'b1, 1'b1, 8'hA2}, // 8
    '{1'b0, 8'h00, 1'b1, 1'b1, 2'd1, 3'd1, 1'b1, 1'b0, 8'h00}, // 9  R7 stop at low
    '{1'b0, 8'h00, 1'b1, 1'b1, 2'd2, 3'd1, 1'b1, 1'b0, 8'h00}, // 10 R6
    '{1'b0, 8'h00, 1'b1, 1'b1, 2'd2, 3'd1, 1'b1, 1'b0, 8'h00}, // 11
    '{1'b0, 8'h00, 1'b1, 1'b1, 2'd0, 3'd1, 1'b1, 1'b0, 8'h00}, // 12 R4 stays below high
    '{1'b0, 8'h00, 1'b0, 1'b1, 2'd0, 3'd1, 1'b1, 1'b0, 8'h00}, // 13 R5 no reads
    '{1'b0, 8'h00, 1'b0, 1'b1, 2'd2, 3'd1, 1'b1, 1'b0, 8'h00}, // 14
    '{1'b0, 8'h00, 1'b0, 1'b1, 2'd2, 3'd1, 1'b1, 1'b0, 8'h00}, // 15
    '{1'b0, 8'h00, 1'b0, 1'b0, 2'd1, 3'd1, 1'b1, 1'b1, 8'hA3}, // 16 R9 no ready
    '{1'b1, 8'hA4, 1'b0, 1'b1, 2'd1, 3'd1, 1'b1, 1'b1, 8'hA3}, // 17 R10 push+pop
    '{1'b0, 8'h00, 1'b0, 1'b1, 2'd1, 3'd1, 1'b1, 1'b1, 8'hA4}, // 18 R8 below low
    '{1'b0, 8'h00, 1'b0, 1'b1, 2'd1, 3'd0, 1'b1, 1'b0, 8'h00}, // 19 R8 empty
    '{1'b0, 8'h00, 1'b1, 1'b1, 2'd2, 3'd0, 1'b1, 1'b0, 8'h00}, // 20
    '{1'b0, 8'h00, 1'b1, 1'b1, 2'd2, 3'd0, 1'b1, 1'b0, 8'h00}, // 21
    '{1'b0, 8'h00, 1'b1, 1'b1, 2'd0, 3'd0, 1'b1, 1'b0, 8'h00}, // 22
    '{1'b1, 8'hB1, 1'b1, 1'b1, 2'd0, 3'd0, 1'b1, 1'b0, 8'h00}, // 23
    '{1'b1, 8'hB2, 1'b1, 1'b1, 2'd0, 3'd1, 1'b1, 1'b0, 8'h00}, // 24
    '{1'b1, 8'hB3, 1'b1, 1'b1, 2'd0, 3'd2, 1'b1, 1'b0, 8'h00}, // 25
    '{1'b1, 8'hB4, 1'b1, 1'b1, 2'd0, 3'd3, 1'b1, 1'b0, 8'h00}, // 26
    '{1'b1, 8'hB5, 1'b1, 1'b1, 2'd2, 3'd4, 1'b0, 1'b0, 8'h00}, // 27 R2 full
    '{1'b1, 8'hB5, 1'b1, 1'b1, 2'd2, 3'd4, 1'b0, 1'b0, 8'h00}, // 28
    '{1'b1, 8'hB5, 1'b1, 1'b0, 2'd1, 3'd4, 1'b0, 1'b1, 8'hB1}, // 29 R2 ignored
    '{1'b0, 8'h00, 1'b1, 1'b1, 2'd1, 3'd4, 1'b0, 1'b1, 8'hB1}, // 30
    '{1'b0, 8'h00, 1'b1, 1'b1, 2'd1, 3'd3, 1'b1, 1'b1, 8'hB2}  // 31
  };

  logic               clk = 1'b0;
  logic               rstN;
  logic [CNT_W-1:0]   highMark;
  logic [CNT_W-1:0]   lowMark;
  logic [TURN_W-1:0]  turnCycles;
  logic               enqValid;
  logic [ENTRY_W-1:0] enqData;
  logic               enqReady;
  logic               rdPending;
  logic               deqValid;
  logic [ENTRY_W-1:0] deqData;
  logic               deqReady;
  logic [1:0]         busMode;
  logic [CNT_W-1:0]   fillLevel;

  int nChecks = 0;
  int nFails  = 0;
  logic done  = 1'b0;

  always #4 clk = ~clk;

  wbuf_drain_ctrl #(
    .ENTRY_W(ENTRY_W),
    .DEPTH  (DEPTH),
    .TURN_W (TURN_W)
  ) u_wbuf_drain_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .highMark  (highMark),
    .lowMark   (lowMark),
    .turnCycles(turnCycles),
    .enqValid  (enqValid),
    .enqData   (enqData),
    .enqReady  (enqReady),
    .rdPending (rdPending),
    .deqValid  (deqValid),
    .deqData   (deqData),
    .deqReady  (deqReady),
    .busMode   (busMode),
    .fillLevel (fillLevel)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic checkAll(input logic [1:0] m, input logic [CNT_W-1:0] f,
                          input logic er, input logic dv, input logic [7:0] d);
    check("R6", "busMode", 32'(busMode), 32'(m));
    check("R2", "fillLevel", 32'(fillLevel), 32'(f));
    check("R2", "enqReady", 32'(enqReady), 32'(er));
    check("R7", "deqValid", 32'(deqValid), 32'(dv));
    if (dv) check("R9", "deqData", 32'(deqData), 32'(d));
  endtask

  initial begin
    rstN = 1'b0; highMark = 3'd3; lowMark = 3'd1; turnCycles = 4'd2;
    enqValid = 1'b0; enqData = '0; rdPending = 1'b1; deqReady = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      enqValid  = VECS[i].ev;
      enqData   = VECS[i].ed;
      rdPending = VECS[i].rp;
      deqReady  = VECS[i].dr;
      #1;
      checkAll(VECS[i].mode, VECS[i].fill, VECS[i].er, VECS[i].dv, VECS[i].data);
    end

    // R1: asynchronous reset in the middle of a drain
    @(negedge clk);
    enqValid = 1'b0; rdPending = 1'b1; deqReady = 1'b1;
    rstN = 1'b0;
    #1;
    checkAll(2'd0, 3'd0, 1'b1, 1'b0, 8'h00);
    @(negedge clk);
    rstN = 1'b1;

    // R6: zero gap switches directly, R5 opportunistic drain
    turnCycles = 4'd0;
    @(negedge clk);
    rdPending = 1'b0; enqValid = 1'b1; enqData = 8'hC1;
    #1;
    checkAll(2'd0, 3'd0, 1'b1, 1'b0, 8'h00);
    @(negedge clk);
    enqValid = 1'b0;
    #1;
    checkAll(2'd0, 3'd1, 1'b1, 1'b0, 8'h00);
    @(negedge clk);
    #1;
    checkAll(2'd1, 3'd1, 1'b1, 1'b1, 8'hC1);   // R6 direct to write
    @(negedge clk);
    #1;
    checkAll(2'd1, 3'd0, 1'b1, 1'b0, 8'h00);   // R8 empty, leaving
    @(negedge clk);
    #1;
    checkAll(2'd0, 3'd0, 1'b1, 1'b0, 8'h00);   // R6 direct to read

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired before completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule